// File: doc/BRIEF.md
# Stepped Soft Mute Attenuator

This block sits in a stereo audio sample path and scales both channels by a shared gain that glides between unity and zero. A mute request input selects the direction. While the request is high the gain walks down to zero one step at a time. Once the request is low again the gain walks back up to unity by the same steps. The gain only ever moves on the sample strobe. A full walk is 128 steps with 8 sample periods per step, so it takes 1024 sample periods.

The request is filtered before it reaches the ramp. A level has to be seen on 8 consecutive strobes before it counts. This stops a mute glitch that is narrower than 8 sample periods from disturbing the gain. If the request reverses while a ramp is still running, the gain turns around at the step it has reached and does not jump. Each channel is a signed 18-bit value. The block registers it as the sample times the gain, rounded back to 18 bits. A status output shows when the gain is exactly zero.

Top module: `smute_attenuator`

## Requirements
- R1: After reset the gain is unity, the filtered request is "released", `silent` is 0 and `out_stb`, `out_l` and `out_r` are 0. Samples then pass through unchanged until a mute request has been filtered in. Reset has this effect even in the middle of a ramp.
- R2: A strobe on `fs_stb` in clock cycle N makes `out_stb` high in cycle N+1. In that same cycle `out_l` and `out_r` carry the results for the samples presented with that strobe. Between strobes the outputs hold their values.
- R3: Each output is floor((x*g + 32768) / 65536). Here x is the signed input sample and g is the gain from the step value in effect before that strobe. The result is always in range, because g never exceeds 65536.
- R4: The gain for step i (0..128) is 4*i*i. Step 0 gives exactly 0 and step 128 gives exactly 65536, which is unity.
- R5: `mute_req` is sampled only on strobes. A new level takes effect on the 8th consecutive strobe that samples it.
- R6: A request level held for fewer than 8 strobes has no effect. The gain and the outputs behave as if it never happened.
- R7: While muting, the step drops by one on every 8th strobe after the request takes effect. From unity, `silent` rises right after the 1032nd strobe counted from the first strobe that samples the request high.
- R8: While released, the step rises by one every 8 strobes up to 128. Starting from silence, `silent` falls after the 16th strobe with the request low. The first output equal to a full-scale input comes on the 1033rd strobe.
- R9: A reversal in mid-ramp continues from the current step in the new direction. The step changes by at most one per strobe.
- R10: `silent` is high exactly when the step is 0. While it is high, every output is 0.
- R11: The step changes only on clock cycles that carry a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fs_stb | input | 1 | One-cycle strobe per sample period; qualifies the samples and the request |
| mute_req | input | 1 | High requests silence, low requests full gain |
| in_l | input | 18 | Left input sample, two's complement |
| in_r | input | 18 | Right input sample, two's complement |
| out_stb | output | 1 | Marks the cycle in which new output samples are present |
| out_l | output | 18 | Left scaled sample |
| out_r | output | 18 | Right scaled sample |
| silent | output | 1 | High while the gain is zero |

## Verification
Some properties are checked on every cycle. The step moves only on a strobe and never by more than one. It never rises while muting and never falls while released. A strobe that disagrees with the candidate request leaves the filtered request unchanged. The outputs are zero once `silent` is set. Only the bench scenarios can show the full-length timing: the 1032-strobe path to silence and the 1033-strobe path back to unity. They also show that a 7-strobe pulse leaves no trace, that a reversal turns around without a jump, and that rounding holds on mixed-sign data at every intermediate gain.

// File: rtl/smute_pkg.sv
package smute_pkg;

  // Default geometry of the attenuator
  localparam int unsigned SMP_W_D  = 18;   // sample width
  localparam int unsigned FRAC_W_D = 16;   // fractional bits of the gain
  localparam int unsigned STEPS_D  = 128;  // steps from zero to unity (power of two)
  localparam int unsigned DWELL_D  = 8;    // strobes spent on each step
  localparam int unsigned HOLD_D   = 8;    // strobes a request must persist

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } ramp_dir_e;

endpackage

// File: rtl/smute_debounce.sv
module smute_debounce #(
  parameter int unsigned HOLD = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic req,
  output logic active
);

  localparam int unsigned CW      = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] FULL  = CW'(HOLD - 1);

  logic          cand_q, cand_d;
  logic [CW-1:0] cnt_q,  cnt_d;
  logic          act_q,  act_d;

  always_comb begin
    cand_d = cand_q;
    cnt_d  = cnt_q;
    act_d  = act_q;
    if (stb) begin
      if (req != cand_q) begin
        cand_d = req;
        cnt_d  = '0;
      end else if (cnt_q != FULL) begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_d == FULL) act_d = cand_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q <= 1'b0;
      cnt_q  <= FULL;
      act_q  <= 1'b0;
    end else begin
      cand_q <= cand_d;
      cnt_q  <= cnt_d;
      act_q  <= act_d;
    end
  end

  assign active = act_q;

  // R6
  new_level_no_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && (req != cand_q)) |=> $stable(act_q));

  // R5
  act_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(act_q));

endmodule

// File: rtl/smute_ramp.sv
module smute_ramp
  import smute_pkg::*;
#(
  parameter int unsigned STEPS  = 128,
  parameter int unsigned DWELL  = 8,
  parameter int unsigned STEP_W = $clog2(STEPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic              mute_on,
  output logic [STEP_W-1:0] step,
  output logic              at_zero
);

  localparam int unsigned PW          = (DWELL > 1) ? $clog2(DWELL) : 1;
  localparam logic [PW-1:0] LAST_PH   = PW'(DWELL - 1);
  localparam logic [STEP_W-1:0] TOP   = STEP_W'(STEPS);

  logic [STEP_W-1:0] step_q, step_d;
  logic [PW-1:0]     phase_q, phase_d;
  ramp_dir_e         dir;
  logic              moving;

  assign dir    = mute_on ? DIR_DOWN : DIR_UP;
  assign moving = (dir == DIR_DOWN) ? (step_q != '0) : (step_q != TOP);

  always_comb begin
    step_d  = step_q;
    phase_d = phase_q;
    if (stb) begin
      if (moving) begin
        if (phase_q == LAST_PH) begin
          phase_d = '0;
          step_d  = (dir == DIR_DOWN) ? step_q - 1'b1 : step_q + 1'b1;
        end else begin
          phase_d = phase_q + 1'b1;
        end
      end else begin
        phase_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q  <= TOP;
      phase_q <= '0;
    end else begin
      step_q  <= step_d;
      phase_q <= phase_d;
    end
  end

  assign step    = step_q;
  assign at_zero = (step_q == '0);

  // R11
  step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(step_q));

  // R9
  step_slew_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> ((step_q == $past(step_q)) ||
             (step_q == STEP_W'($past(step_q) + 1'b1)) ||
             (step_q == STEP_W'($past(step_q) - 1'b1))));

  // R7
  mute_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && mute_on) |=> (step_q <= $past(step_q)));

  // R8
  release_no_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !mute_on) |=> (step_q >= $past(step_q)));

  // R4
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= TOP);

endmodule

// File: rtl/smute_scale.sv
module smute_scale #(
  parameter int unsigned SMP_W  = 18,
  parameter int unsigned FRAC_W = 16,
  parameter int unsigned STEP_W = 8,
  parameter int unsigned SHIFT  = 2
) (
  input  logic signed [SMP_W-1:0]  sample,
  input  logic        [STEP_W-1:0] step,
  output logic signed [SMP_W-1:0]  scaled
);

  localparam int unsigned GAIN_W = FRAC_W + 1;
  localparam int unsigned PROD_W = SMP_W + GAIN_W + 1;
  localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) << (FRAC_W - 1);

  logic [2*STEP_W-1:0]        sq;
  logic [GAIN_W-1:0]          gain;
  logic signed [PROD_W-1:0]   prod;
  logic signed [PROD_W-1:0]   rnd;
  logic                       unused_bits;

  // Gain curve: square of the step index, scaled so the last step is unity
  assign sq     = step * step;
  assign gain   = GAIN_W'(sq) << SHIFT;
  assign prod   = $signed(sample) * $signed({1'b0, gain});
  assign rnd    = prod + HALF;
  assign scaled = rnd[FRAC_W +: SMP_W];

  assign unused_bits = ^{rnd[FRAC_W-1:0], rnd[PROD_W-1:FRAC_W+SMP_W]};

endmodule

// File: rtl/smute_attenuator.sv
module smute_attenuator
  import smute_pkg::*;
#(
  parameter int unsigned SMP_W  = SMP_W_D,
  parameter int unsigned FRAC_W = FRAC_W_D,
  parameter int unsigned STEPS  = STEPS_D,
  parameter int unsigned DWELL  = DWELL_D,
  parameter int unsigned HOLD   = HOLD_D
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fs_stb,
  input  logic                    mute_req,
  input  logic signed [SMP_W-1:0] in_l,
  input  logic signed [SMP_W-1:0] in_r,
  output logic                    out_stb,
  output logic signed [SMP_W-1:0] out_l,
  output logic signed [SMP_W-1:0] out_r,
  output logic                    silent
);

  localparam int unsigned STEP_W      = $clog2(STEPS + 1);
  localparam int unsigned CURVE_SHIFT = FRAC_W - 2 * $clog2(STEPS);
  localparam int unsigned CH          = 2;

  // Reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  logic              mute_on;
  logic [STEP_W-1:0] step;
  logic              at_zero;

  smute_debounce #(.HOLD(HOLD)) filt_i (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .stb    (fs_stb),
    .req    (mute_req),
    .active (mute_on)
  );

  smute_ramp #(.STEPS(STEPS), .DWELL(DWELL), .STEP_W(STEP_W)) ramp_i (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .stb     (fs_stb),
    .mute_on (mute_on),
    .step    (step),
    .at_zero (at_zero)
  );

  logic signed [SMP_W-1:0] smp_in  [CH];
  logic signed [SMP_W-1:0] smp_scl [CH];
  logic signed [SMP_W-1:0] smp_q   [CH];
  logic signed [SMP_W-1:0] smp_d   [CH];

  assign smp_in[0] = in_l;
  assign smp_in[1] = in_r;

  for (genvar c = 0; c < CH; c++) begin : g_chan
    smute_scale #(
      .SMP_W (SMP_W),
      .FRAC_W(FRAC_W),
      .STEP_W(STEP_W),
      .SHIFT (CURVE_SHIFT)
    ) scl_i (
      .sample(smp_in[c]),
      .step  (step),
      .scaled(smp_scl[c])
    );

    always_comb begin
      smp_d[c] = smp_q[c];
      if (fs_stb) smp_d[c] = smp_scl[c];
    end

    always_ff @(posedge clk or negedge rst_s_n) begin
      if (!rst_s_n) smp_q[c] <= '0;
      else          smp_q[c] <= smp_d[c];
    end
  end

  logic ostb_q;
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) ostb_q <= 1'b0;
    else          ostb_q <= fs_stb;
  end

  assign out_stb = ostb_q;
  assign out_l   = smp_q[0];
  assign out_r   = smp_q[1];
  assign silent  = at_zero;

  // R10
  silent_zero_out_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (out_stb && $past(silent)) |-> ((out_l == '0) && (out_r == '0)));

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !fs_stb |=> ($stable(out_l) && $stable(out_r)));

endmodule

// File: tb/smute_attenuator_tb_top.sv
module smute_attenuator_tb_top;

  localparam int GAP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fs_stb = 1'b0;
  logic mute_req = 1'b0;
  logic signed [17:0] in_l = '0;
  logic signed [17:0] in_r = '0;
  logic out_stb;
  logic signed [17:0] out_l;
  logic signed [17:0] out_r;
  logic silent;

  always #5 clk = ~clk;

  smute_attenuator dut_i (
    .clk(clk), .rst_n(rst_n), .fs_stb(fs_stb), .mute_req(mute_req),
    .in_l(in_l), .in_r(in_r), .out_stb(out_stb),
    .out_l(out_l), .out_r(out_r), .silent(silent)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {
    int    l;
    int    r;
    string tag;
  } exp_t;
  exp_t sb[$];

  // Requirement-level model state
  int m_cand, m_cnt, m_eff, m_phase, m_step;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int scale_ref(input int x, input int st);
    longint p;
    p = longint'(x) * longint'(4 * st * st) + 64'sd32768;
    return int'(p >>> 16);
  endfunction

  task automatic model_reset();
    m_cand = 0; m_cnt = 7; m_eff = 0; m_phase = 0; m_step = 128;
  endtask

  task automatic model_update(input int req);
    bit mv;
    mv = m_eff ? (m_step != 0) : (m_step != 128);
    if (mv) begin
      if (m_phase == 7) begin
        m_phase = 0;
        m_step  = m_eff ? m_step - 1 : m_step + 1;
      end else m_phase++;
    end else m_phase = 0;
    if (req != m_cand) begin
      m_cand = req; m_cnt = 0;
    end else if (m_cnt != 7) begin
      m_cnt++;
      if (m_cnt == 7) m_eff = m_cand;
    end
  endtask

  task automatic do_strobe(input int req, input int l, input int r, input string tag);
    @(negedge clk);
    mute_req = req[0];
    in_l = l[17:0];
    in_r = r[17:0];
    fs_stb = 1'b1;
    sb.push_back('{scale_ref(l, m_step), scale_ref(r, m_step), tag});
    model_update(req);
    @(negedge clk);
    fs_stb = 1'b0;
    // R10: flag tracks a zero gain
    check(silent == (m_step == 0), "R10", "silent", longint'(silent), longint'(m_step == 0));
    repeat (GAP - 2) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    fs_stb = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    repeat (4) @(negedge clk);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (out_stb) begin
      if (sb.size() == 0) begin
        check(1'b0, "R2", "unexpected out_stb", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(out_l == e.l, e.tag, "out_l", longint'(out_l), longint'(e.l));
        check(out_r == e.r, e.tag, "out_r", longint'(out_r), longint'(e.r));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int first;
    int prev;
    int d;
    model_reset();
    do_reset();

    // R1: reset state
    check(silent == 1'b0, "R1", "silent after reset", longint'(silent), 0);
    check(out_stb == 1'b0, "R1", "out_stb after reset", longint'(out_stb), 0);
    check(out_l == 0 && out_r == 0, "R1", "outputs after reset", longint'(out_l), 0);

    // R1 R4: unity pass-through with several patterns
    do_strobe(0, 131071, -131072, "R4");
    do_strobe(0, -1, 1, "R1");
    do_strobe(0, 0, 12345, "R1");
    do_strobe(0, -77777, 65535, "R4");
    check(out_l == -77777 && out_r == 65535, "R4", "unity gain output",
          longint'(out_l), -77777);

    // R6: a 7-strobe pulse leaves the gain untouched
    for (int k = 0; k < 7; k++) do_strobe(1, 100000 - k, -100000 + k, "R6");
    for (int k = 0; k < 10; k++) do_strobe(0, 100000, -3, "R6");
    check(out_l == 100000 && out_r == -3, "R6", "gain after short pulse",
          longint'(out_l), 100000);

    // R7 R3: full mute with mixed-sign data
    first = 0;
    for (int k = 1; k <= 1100; k++) begin
      int l;
      l = ((k * 7919) % 262144) - 131072;
      do_strobe(1, l, -l - 1, "R3");
      if (silent && first == 0) first = k;
    end
    check(first == 1032, "R7", "strobes to silence", first, 1032);

    // R10: outputs stay zero while silent
    for (int k = 0; k < 16; k++) do_strobe(1, 131071, -131072, "R10");
    check(out_l == 0 && out_r == 0, "R10", "silent output", longint'(out_l), 0);

    // R8: release ramps back to unity
    first = 0;
    prev = 0;
    for (int k = 1; k <= 1100; k++) begin
      do_strobe(0, 131071, -131072, "R8");
      if (!silent && prev == 0) prev = k;
      if (out_l == 131071 && first == 0) first = k;
    end
    check(prev == 16, "R8", "strobes until silent clears", prev, 16);
    check(first == 1033, "R8", "strobes to full gain", first, 1033);

    // R9: reversal mid-ramp, no jump and no excursion to silence
    prev = 131071;
    for (int k = 1; k <= 300; k++) begin
      do_strobe(1, 131071, 131071, "R9");
      d = out_l - prev;
      if (d < 0) d = -d;
      check(d <= 2100, "R9", "step size muting", d, 2100);
      prev = out_l;
    end
    for (int k = 1; k <= 400; k++) begin
      do_strobe(0, 131071, 131071, "R9");
      d = out_l - prev;
      if (d < 0) d = -d;
      check(d <= 2100, "R9", "step size reversing", d, 2100);
      check(!silent, "R9", "no silence on reversal", longint'(silent), 0);
      prev = out_l;
    end

    // R1: reset in mid-ramp restores unity
    for (int k = 0; k < 200; k++) do_strobe(1, 5000, -5000, "R7");
    do_reset();
    check(silent == 1'b0, "R1", "silent after mid-ramp reset", longint'(silent), 0);
    do_strobe(0, 5000, -5000, "R1");
    check(out_l == 5000 && out_r == -5000, "R1", "unity after reset",
          longint'(out_l), 5000);

    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R2", "pending expected items", sb.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule